// File: doc/BRIEF.md
# Dual-Slope Conversion Sequencer

This block is the digital half of an integrating dual-slope converter. The integrator, its analog switches and the zero-crossing comparator sit outside it. A start request begins a run-up phase in which the unknown input is connected to the integrator for a fixed 2^N clocks, where N is the result width. The block then switches the integrator to a reference of opposite polarity and counts clocks until the comparator shows that the integrator output has crossed zero. A zero-integrator phase of fixed length follows, and the count is published with a one-clock done pulse.

The comparator arrives asynchronously and passes through a synchroniser. A crossing is any change of the synchronised level, so either input polarity works. If no crossing is seen within 2^N reference clocks, the phase stops. The result is then forced to all ones and an overrange flag is raised. One conversion therefore takes 2^N + (de-integrate clocks) + (zero clocks), which depends on the input.

Top module: `dual_slope_ctrl`

## Requirements
- R1: While reset is held and immediately after it, busy, done, overRange, selInput, selRef and selZero are 0 and result is 0.
- R2: A startReq high in an idle cycle makes busy and selInput high from the next clock. selInput then stays high for exactly 2^RES_BITS clocks (256 with defaults).
- R3: When selInput falls, selRef rises on the same edge. With the default two synchroniser stages, a comparator change applied during the k-th clock of selRef produces result = k+1, and selRef stays high for k+2 clocks.
- R4: A crossing is a change of the synchronised comparator level in either direction, low-to-high or high-to-low.
- R5: If no crossing is recognised by the 2^RES_BITS-th reference clock, selRef lasts exactly 2^RES_BITS clocks, result becomes all ones (255 with defaults) and overRange becomes 1. A crossing recognised on that final clock gives result all ones with overRange 0.
- R6: Every de-integrate phase, whether normal or overrange, is followed by selZero high for exactly ZERO_CLKS clocks (16 with defaults).
- R7: done is high for exactly one clock, in the first cycle after selZero falls, with busy already 0. result and overRange change only on the edge that raises done, and they are held at all other times.
- R8: A startReq received while busy has no effect on the running conversion's phase lengths, and no second conversion follows it.
- R9: At most one of selInput, selRef and selZero is high at any time, and none is high while busy is 0.
- R10: An in-range conversion that follows an overrange one clears overRange.
- R11: Comparator changes outside the de-integrate phase are ignored. A change during run-up neither shortens run-up nor affects the count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startReq | input | 1 | Conversion request, sampled while idle |
| cmpAsync | input | 1 | Unsynchronised zero-crossing comparator level |
| selInput | output | 1 | Connect unknown input to integrator |
| selRef | output | 1 | Connect opposite-polarity reference to integrator |
| selZero | output | 1 | Short integrator back to zero |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-clock pulse with a fresh result |
| result | output | RES_BITS | Published de-integrate count |
| overRange | output | 1 | Last conversion saturated |

## Verification
Conversions are run with crossings at several positions:
- The earliest position separates the fixed synchroniser offset from an off-by-one in the counter.
- A mid-scale position checks the linear count.
- The last in-range clock and the first out-of-range clock sit on either side of the saturation boundary.
- A run with no crossing at all checks saturation on its own.

Because the comparator level is never restored between runs, rising and falling crossings alternate. A comparator toggle during run-up, a start pulse during busy, and an in-range run after an overrange one check that stray inputs are ignored and that the flag clears.

// File: rtl/dsc_pkg.sv
package dsc_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_RUNUP = 2'd1,
    PH_DEINT = 2'd2,
    PH_ZERO  = 2'd3
  } phase_e;

  // Commands from the sequencer to the datapath
  typedef struct packed {
    logic cntClear;
    logic cntInc;
    logic zeroClear;
    logic zeroInc;
    logic capCount;
    logic capSat;
    logic publish;
  } dpStrobe_t;

  // Status returned from the datapath
  typedef struct packed {
    logic cntLast;
    logic zeroLast;
    logic crossSeen;
  } dpStatus_t;

endpackage

// File: rtl/dsc_datapath.sv
module dsc_datapath
  import dsc_pkg::*;
#(
  parameter int RES_BITS    = 8,
  parameter int ZERO_CLKS   = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cmpAsync,
  input  dpStrobe_t           strobe,
  output dpStatus_t           status,
  output logic [RES_BITS-1:0] resultQ,
  output logic                overRangeQ
);

  localparam int ZW = (ZERO_CLKS > 1) ? $clog2(ZERO_CLKS) : 1;
  localparam logic [RES_BITS-1:0] CNT_MAX = {RES_BITS{1'b1}};
  localparam logic [ZW-1:0] ZERO_MAX = ZW'(ZERO_CLKS - 1);

  // Comparator synchroniser chain
  logic [SYNC_STAGES-1:0] syncChain;
  logic                   cmpPrev;
  logic                   cmpSync;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncChain[0] <= 1'b0;
    else       syncChain[0] <= cmpAsync;
  end

  generate
    for (genvar gi = 1; gi < SYNC_STAGES; gi++) begin : g_sync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncChain[gi] <= 1'b0;
        else       syncChain[gi] <= syncChain[gi-1];
      end
    end
  endgenerate

  assign cmpSync = syncChain[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cmpPrev <= 1'b0;
    else       cmpPrev <= cmpSync;
  end

  // Phase counter shared by run-up and de-integrate
  logic [RES_BITS-1:0] phaseCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                phaseCnt <= '0;
    else if (strobe.cntClear) phaseCnt <= '0;
    else if (strobe.cntInc)   phaseCnt <= phaseCnt + 1'b1;
  end

  // Zero-integrator timer
  logic [ZW-1:0] zeroCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 zeroCnt <= '0;
    else if (strobe.zeroClear) zeroCnt <= '0;
    else if (strobe.zeroInc)   zeroCnt <= zeroCnt + 1'b1;
  end

  // Captured count, published at the end of the zero phase
  logic [RES_BITS-1:0] capVal;
  logic                capOvr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capVal <= '0;
      capOvr <= 1'b0;
    end else if (strobe.capCount) begin
      capVal <= phaseCnt;
      capOvr <= 1'b0;
    end else if (strobe.capSat) begin
      capVal <= CNT_MAX;
      capOvr <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resultQ    <= '0;
      overRangeQ <= 1'b0;
    end else if (strobe.publish) begin
      resultQ    <= capVal;
      overRangeQ <= capOvr;
    end
  end

  always_comb begin
    status.cntLast   = (phaseCnt == CNT_MAX);
    status.zeroLast  = (zeroCnt == ZERO_MAX);
    status.crossSeen = cmpSync ^ cmpPrev;
  end

endmodule

// File: rtl/dsc_control.sv
module dsc_control
  import dsc_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      startReq,
  input  dpStatus_t status,
  output dpStrobe_t strobe,
  output logic      selInput,
  output logic      selRef,
  output logic      selZero,
  output logic      busy,
  output logic      doneQ
);

  phase_e phase, phaseNext;
  logic   doneNext;

  always_comb begin
    phaseNext = phase;
    doneNext  = 1'b0;
    strobe    = '0;
    unique case (phase)
      PH_IDLE: begin
        if (startReq) begin
          strobe.cntClear = 1'b1;
          phaseNext       = PH_RUNUP;
        end
      end
      PH_RUNUP: begin
        if (status.cntLast) begin
          strobe.cntClear = 1'b1;
          phaseNext       = PH_DEINT;
        end else begin
          strobe.cntInc = 1'b1;
        end
      end
      PH_DEINT: begin
        if (status.crossSeen) begin
          strobe.capCount  = 1'b1;
          strobe.zeroClear = 1'b1;
          phaseNext        = PH_ZERO;
        end else if (status.cntLast) begin
          strobe.capSat    = 1'b1;
          strobe.zeroClear = 1'b1;
          phaseNext        = PH_ZERO;
        end else begin
          strobe.cntInc = 1'b1;
        end
      end
      PH_ZERO: begin
        if (status.zeroLast) begin
          strobe.publish = 1'b1;
          doneNext       = 1'b1;
          phaseNext      = PH_IDLE;
        end else begin
          strobe.zeroInc = 1'b1;
        end
      end
      default: phaseNext = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= PH_IDLE;
      doneQ <= 1'b0;
    end else begin
      phase <= phaseNext;
      doneQ <= doneNext;
    end
  end

  always_comb begin
    selInput = (phase == PH_RUNUP);
    selRef   = (phase == PH_DEINT);
    selZero  = (phase == PH_ZERO);
    busy     = (phase != PH_IDLE);
  end

endmodule

// File: rtl/dual_slope_ctrl.sv
module dual_slope_ctrl
  import dsc_pkg::*;
#(
  parameter int RES_BITS    = 8,
  parameter int ZERO_CLKS   = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                startReq,
  input  logic                cmpAsync,
  output logic                selInput,
  output logic                selRef,
  output logic                selZero,
  output logic                busy,
  output logic                done,
  output logic [RES_BITS-1:0] result,
  output logic                overRange
);

  dpStrobe_t strobe;
  dpStatus_t status;

  dsc_control u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .startReq (startReq),
    .status   (status),
    .strobe   (strobe),
    .selInput (selInput),
    .selRef   (selRef),
    .selZero  (selZero),
    .busy     (busy),
    .doneQ    (done)
  );

  dsc_datapath #(
    .RES_BITS    (RES_BITS),
    .ZERO_CLKS   (ZERO_CLKS),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .cmpAsync   (cmpAsync),
    .strobe     (strobe),
    .status     (status),
    .resultQ    (result),
    .overRangeQ (overRange)
  );

endmodule

// File: rtl/dual_slope_ctrl_chk.sv
module dual_slope_ctrl_chk #(
  parameter int RES_BITS  = 8,
  parameter int ZERO_CLKS = 16
) (
  input logic                clk,
  input logic                rstN,
  input logic                startReq,
  input logic                selInput,
  input logic                selRef,
  input logic                selZero,
  input logic                busy,
  input logic                done,
  input logic [RES_BITS-1:0] result,
  input logic                overRange
);

  localparam int FULL = 2 ** RES_BITS;

  int runLen, refLen, zeroLen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runLen  <= 0;
      refLen  <= 0;
      zeroLen <= 0;
    end else begin
      runLen  <= selInput ? runLen + 1 : 0;
      refLen  <= selRef ? refLen + 1 : 0;
      zeroLen <= selZero ? zeroLen + 1 : 0;
    end
  end

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({selInput, selRef, selZero})); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !(selInput || selRef || selZero)); // R9
  AST_START_ENTERS_RUNUP: assert property (@(posedge clk) disable iff (!rstN)
    (startReq && !busy) |=> (busy && selInput)); // R2
  AST_RUNUP_LEN: assert property (@(posedge clk) disable iff (!rstN)
    $fell(selInput) |-> (runLen == FULL)); // R2
  AST_RUNUP_TO_REF: assert property (@(posedge clk) disable iff (!rstN)
    $fell(selInput) |-> selRef); // R3
  AST_REF_BOUNDED: assert property (@(posedge clk) disable iff (!rstN)
    refLen <= FULL); // R5
  AST_OVR_SATURATED: assert property (@(posedge clk) disable iff (!rstN)
    overRange |-> (&result)); // R5
  AST_REF_TO_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    $fell(selRef) |-> selZero); // R6
  AST_ZERO_LEN: assert property (@(posedge clk) disable iff (!rstN)
    $fell(selZero) |-> (zeroLen == ZERO_CLKS)); // R6
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R7
  AST_DONE_AFTER_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && $past(selZero))); // R7
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> ($stable(result) && $stable(overRange))); // R7
  AST_BUSY_ENDS_WITH_DONE: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> (busy || done)); // R8

endmodule

bind dual_slope_ctrl dual_slope_ctrl_chk #(
  .RES_BITS  (RES_BITS),
  .ZERO_CLKS (ZERO_CLKS)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .startReq  (startReq),
  .selInput  (selInput),
  .selRef    (selRef),
  .selZero   (selZero),
  .busy      (busy),
  .done      (done),
  .result    (result),
  .overRange (overRange)
);

// File: tb/dual_slope_ctrl_tb_top.sv
`timescale 1ns/1ps
module dual_slope_ctrl_tb_top;

  localparam int N     = 8;
  localparam int ZCLK  = 16;
  localparam int FULL  = 2 ** N;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         startReq = 1'b0;
  logic         cmpAsync = 1'b0;
  logic         selInput, selRef, selZero, busy, done, overRange;
  logic [N-1:0] result;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [N-1:0] prevRes = '0;
  logic         prevOvr = 1'b0;

  always #2 clk = ~clk;

  dual_slope_ctrl #(.RES_BITS(N), .ZERO_CLKS(ZCLK), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rstN(rstN), .startReq(startReq), .cmpAsync(cmpAsync),
    .selInput(selInput), .selRef(selRef), .selZero(selZero),
    .busy(busy), .done(done), .result(result), .overRange(overRange)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // One conversion: flipAt = reference clock on which the comparator toggles
  // (0 = never), preTog toggles it during run-up, lateStart pulses start mid run-up.
  task automatic runConv(input int flipAt, input bit preTog, input bit lateStart);
    int inCyc = 0, refCyc = 0, zeroCyc = 0, guard = 0;
    bit inRange = (flipAt > 0) && (flipAt + 1 <= FULL - 1);
    int expRef = inRange ? flipAt + 2 : FULL;
    int expRes = inRange ? flipAt + 1 : FULL - 1;
    bit expOvr = !inRange;
    bit busyDrop = 1'b0;
    @(negedge clk) startReq = 1'b1;
    @(negedge clk) startReq = 1'b0;
    chk(busy && selInput, "R2", "busy/selInput after start", {busy, selInput}, 3);
    do begin
      if (selInput) inCyc++;
      if (selRef) refCyc++;
      if (selZero) zeroCyc++;
      if (!busy) busyDrop = 1'b1;
      if ((selInput + selRef + selZero) != 1) busyDrop = 1'b1;
      if (preTog && selInput && inCyc == 10) cmpAsync = ~cmpAsync;
      if (selRef && refCyc == flipAt) cmpAsync = ~cmpAsync;
      startReq = lateStart && selInput && (inCyc == 20);
      if (selZero && zeroCyc == 1)
        chk(result == prevRes && overRange == prevOvr, "R7",
            "result held during conversion", result, prevRes);
      @(negedge clk);
      guard++;
    end while (!done && guard < 4000);
    startReq = 1'b0;
    chk(!busyDrop, "R9", "exactly one select while busy", busyDrop, 0);
    chk(done && !busy, "R7", "done with busy low", {done, busy}, 2);
    chk(inCyc == FULL, lateStart ? "R8" : "R2", "run-up length", inCyc, FULL);
    chk(refCyc == expRef, expOvr ? "R5" : "R3", "de-integrate length", refCyc, expRef);
    chk(zeroCyc == ZCLK, "R6", "zero phase length", zeroCyc, ZCLK);
    chk(result == expRes, expOvr ? "R5" : "R3", "result", result, expRes);
    chk(overRange == expOvr, expOvr ? "R5" : "R10", "overRange", overRange, expOvr);
    prevRes = result;
    prevOvr = overRange;
    @(negedge clk);
    chk(!done, "R7", "done single pulse", done, 0);
    repeat (5) @(negedge clk);
    chk(!busy, lateStart ? "R8" : "R9", "stays idle", busy, 0);
    chk(result == prevRes, "R7", "result held while idle", result, prevRes);
  endtask

  task automatic testReset();
    chk(!busy && !done && !overRange, "R1", "status in reset", {busy, done, overRange}, 0);
    chk(!selInput && !selRef && !selZero, "R1", "selects in reset",
        {selInput, selRef, selZero}, 0);
    chk(result == '0, "R1", "result in reset", result, 0);
  endtask

  initial begin : watchdog
    while (cycles < 200000) begin
      @(posedge clk);
      cycles++;
    end
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    testReset();
    runConv(100, 1'b0, 1'b0);     // R3 mid-scale, rising crossing (R4)
    runConv(1, 1'b0, 1'b0);       // R3 earliest crossing, falling (R4)
    runConv(FULL - 2, 1'b0, 1'b0); // R5 crossing on final clock, no overrange
    runConv(0, 1'b0, 1'b0);       // R5 no crossing at all
    runConv(FULL - 1, 1'b0, 1'b0); // R5 crossing one clock too late
    runConv(37, 1'b0, 1'b0);      // R10 clears overRange
    runConv(50, 1'b1, 1'b0);      // R11 comparator toggle during run-up
    runConv(60, 1'b0, 1'b1);      // R8 start while busy
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule